// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Transmitter

This block drives one packet onto a differential two-wire bus at low speed. Each bit lasts eight clocks. A single `start` pulse begins the packet. The transmitter then takes the bus, holds the idle level for one bit and sends the synchronisation byte by itself. After that it streams the payload bytes, which it pulls over a ready/valid byte port. The line coding is NRZI with bit stuffing. The packet closes with an end-of-packet made of two bit times of both lines low and one bit time of idle. The drivers are then released and `done` pulses.

The byte count given with `start` includes the sync byte. The block fetches the next byte while the current byte is still being shifted out, so no gap appears between bytes. If the source has no byte ready when one is needed, the packet is cut short and the error is flagged. A handshake mode sends a two-byte reply made of sync plus one PID byte taken from a side input. In this mode the byte port stays unused. The block does not choose responses and does not compute CRCs.

Top module: `usb_ls_tx`

## Requirements
- R1: A `start` pulse while idle asserts `oe` and drives J (`dp`=0, `dm`=1) from the next clock. A `start` pulse while a packet is in progress has no effect on that packet.
- R2: J is held for exactly one bit time (CLKS_PER_BIT clocks) before the first bit. Every line symbol that follows lasts exactly CLKS_PER_BIT clocks.
- R3: The first byte sent is the sync value 0x80, least significant bit first. `byte_cnt` counts the sync byte, so `byte_cnt`-1 payload bytes follow it. A count of 0 or 1 sends the sync byte only.
- R4: Bits are sent LSB first with NRZI coding. A 0 bit toggles the line between J (`dp`=0,`dm`=1) and K (`dp`=1,`dm`=0). A 1 bit holds the line. Both lines are never high together while `oe` is high.
- R5: After six consecutive 1 bits, one extra toggle (a stuffed 0) is sent. The run count carries across byte boundaries. A run that ends the last byte is also stuffed before the end-of-packet. A sent 0 or a stuffed bit clears the run count.
- R6: After the last bit, both lines are driven low for exactly two bit times, then J for one bit time. After that `oe` falls, and `done` is high for that single first released cycle.
- R7: `in_ready` is high only while a payload byte is still owed and the one-byte holding register is empty. It is never high while `oe` is low. Every accepted byte is sent in acceptance order with no gap.
- R8: If a payload byte is owed at a byte boundary and none is held, the packet ends there, after any pending stuffed bit. `underrun` then stays at 1 until the next accepted `start`, which clears it.
- R9: With `hs_mode`=1 at `start`, the packet is sync followed by `hs_pid`. `byte_cnt` is ignored and `in_ready` stays low for the whole packet.
- R10: While `oe` is low, `dp` and `dm` are both driven low.
- R11: After reset, `oe`, `dp`, `dm`, `in_ready`, `done` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit time is CLKS_PER_BIT cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a packet (accepted only when idle) |
| hs_mode | input | 1 | Send sync plus `hs_pid` instead of streamed bytes |
| hs_pid | input | 8 | PID byte for handshake mode |
| byte_cnt | input | CNT_W | Packet length in bytes, sync included |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block accepts `in_data` this cycle |
| dp | output | 1 | Positive line level |
| dm | output | 1 | Negative line level |
| oe | output | 1 | Line driver enable |
| done | output | 1 | One-cycle pulse when the bus is released |
| underrun | output | 1 | Sticky flag: payload byte missing at a boundary |

## Verification
Every single-byte payload value is sent in turn. Each run checks how the toggle-versus-hold coding interacts with runs of ones, and with stuffing just before the end-of-packet. Multi-byte patterns are also sent: all zeros (a toggle every bit), all ones (repeated stuffing across bytes), and a run that starts in one byte and finishes in the next. These show that the run history survives byte boundaries and that bytes follow each other without gaps. Lengths 0 and 1, handshake replies with bytes offered on the unused port, and sources that supply too few bytes separate the length rule, the port gating and the early end on underrun. The bench decodes each packet one symbol per bit time against a sequence it computes itself.

// File: rtl/usb_ls_tx_pkg.sv
// Shared types and constants for the low-speed packet transmitter.
package usb_ls_tx_pkg;

    // Packet phases seen by the line driver.
    typedef enum logic [2:0] {
        ST_IDLE,   // bus released
        ST_LEAD,   // idle level held before the first bit
        ST_DATA,   // coded bits
        ST_SE0,    // both lines low
        ST_TAIL    // idle level before release
    } tx_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam int         RUN_MAX   = 6;

endpackage

// File: rtl/usb_ls_tx_timer.sv
// Bit-time timer. Counts clocks inside one bit time while the packet runs
// and flags the last clock of each bit time. Assumes CLKS_PER_BIT >= 2.
module usb_ls_tx_timer #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bit_end
);
    localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

    logic [TW-1:0] tick;

    assign bit_end = run && (tick == TW'(CLKS_PER_BIT - 1));

    // Clock counter within the current bit time; held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tick <= '0;
        end else if (bit_end) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

endmodule

// File: rtl/usb_ls_tx_feed.sv
// Byte supply for the serializer. Tracks the payload bytes still owed,
// keeps a one-byte holding register filled from the ready/valid port, and
// in handshake mode presents the latched PID instead. Assumes the
// serializer raises take or miss at most once per byte boundary.
module usb_ls_tx_feed #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             active,
    input  logic             hs_mode,
    input  logic [7:0]       hs_pid,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             take,
    input  logic             miss,
    output logic [7:0]       nb_data,
    output logic             nb_have,
    output logic             nb_more,
    output logic             in_ready
);
    logic             hs_q;
    logic [7:0]       pid_q;
    logic [7:0]       hold_q;
    logic             hold_v;
    logic [CNT_W-1:0] owed;
    logic [CNT_W-1:0] to_fetch;
    logic [CNT_W-1:0] payload_cnt;

    assign payload_cnt = (byte_cnt == '0) ? '0 : byte_cnt - 1'b1;
    assign in_ready    = active && !hs_q && !hold_v && (to_fetch != '0) && !miss;
    assign nb_have     = hs_q || hold_v;
    assign nb_data     = hs_q ? pid_q : hold_q;
    assign nb_more     = (owed != '0);

    // Owed/fetch counters and the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q     <= 1'b0;
            pid_q    <= '0;
            hold_q   <= '0;
            hold_v   <= 1'b0;
            owed     <= '0;
            to_fetch <= '0;
        end else if (init) begin
            hs_q     <= hs_mode;
            pid_q    <= hs_pid;
            hold_v   <= 1'b0;
            owed     <= hs_mode ? CNT_W'(1) : payload_cnt;
            to_fetch <= hs_mode ? '0 : payload_cnt;
        end else begin
            if (miss) begin
                owed     <= '0;
                to_fetch <= '0;
            end else if (take) begin
                owed   <= owed - 1'b1;
                hold_v <= 1'b0;
            end
            if (in_ready && in_valid) begin
                hold_q   <= in_data;
                hold_v   <= 1'b1;
                to_fetch <= to_fetch - 1'b1;
            end
        end
    end

endmodule

// File: rtl/usb_ls_tx_enc.sv
// Serializer with NRZI coding and bit stuffing. On each advance it either
// sends a stuffed toggle (after six ones) or the next byte bit LSB first,
// and at a byte boundary loads the next byte from the feed. Assumes
// advance pulses come once per bit time.
module usb_ls_tx_enc
    import usb_ls_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       adv,
    input  logic [7:0] nb_data,
    input  logic       nb_have,
    input  logic       nb_more,
    output logic       lvl,
    output logic       drained,
    output logic       stuff_due,
    output logic       nb_take,
    output logic       nb_miss
);
    logic [7:0] sh;
    logic [2:0] bitn;
    logic [2:0] ones;
    logic       send;
    logic       last_bit;

    assign stuff_due = (ones == 3'(RUN_MAX));
    assign send      = adv && !stuff_due && !drained;
    assign last_bit  = (bitn == 3'd7);
    assign nb_take   = send && last_bit && nb_more && nb_have;
    assign nb_miss   = send && last_bit && nb_more && !nb_have;

    // Line level, run counter and bit shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            bitn    <= '0;
            ones    <= '0;
            lvl     <= 1'b1;
            drained <= 1'b1;
        end else if (init) begin
            sh      <= SYNC_BYTE;
            bitn    <= '0;
            ones    <= '0;
            lvl     <= 1'b1;
            drained <= 1'b0;
        end else if (adv && stuff_due) begin
            lvl  <= ~lvl;
            ones <= '0;
        end else if (send) begin
            if (sh[0]) begin
                ones <= ones + 1'b1;
            end else begin
                lvl  <= ~lvl;
                ones <= '0;
            end
            if (last_bit) begin
                bitn <= '0;
                if (nb_take) begin
                    sh <= nb_data;
                end else begin
                    sh      <= '0;
                    drained <= 1'b1;
                end
            end else begin
                sh   <= sh >> 1;
                bitn <= bitn + 1'b1;
            end
        end
    end

endmodule

// File: rtl/usb_ls_tx.sv
// Low-speed packet transmitter top. Sequences lead-in J, coded bits,
// end-of-packet and release, and maps the phase to the two line levels and
// the driver enable. Assumes start is ignored unless the block is idle.
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hs_mode,
    input  logic [7:0]       hs_pid,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             dp,
    output logic             dm,
    output logic             oe,
    output logic             done,
    output logic             underrun
);
    tx_state_e  state;
    logic       se0_second;
    logic       done_q;
    logic       underrun_q;
    logic       run;
    logic       init;
    logic       bit_end;
    logic       adv;
    logic       lvl;
    logic       drained;
    logic       stuff_due;
    logic       nb_take;
    logic       nb_miss;
    logic       nb_have;
    logic       nb_more;
    logic [7:0] nb_data;
    logic       bits_over;

    assign run       = (state != ST_IDLE);
    assign init      = start && (state == ST_IDLE);
    assign bits_over = drained && !stuff_due;
    assign adv       = bit_end && ((state == ST_LEAD) ||
                                   ((state == ST_DATA) && !bits_over));

    usb_ls_tx_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .bit_end (bit_end)
    );

    usb_ls_tx_feed #(.CNT_W(CNT_W)) u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init),
        .active   (run),
        .hs_mode  (hs_mode),
        .hs_pid   (hs_pid),
        .byte_cnt (byte_cnt),
        .in_data  (in_data),
        .in_valid (in_valid),
        .take     (nb_take),
        .miss     (nb_miss),
        .nb_data  (nb_data),
        .nb_have  (nb_have),
        .nb_more  (nb_more),
        .in_ready (in_ready)
    );

    usb_ls_tx_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (init),
        .adv       (adv),
        .nb_data   (nb_data),
        .nb_have   (nb_have),
        .nb_more   (nb_more),
        .lvl       (lvl),
        .drained   (drained),
        .stuff_due (stuff_due),
        .nb_take   (nb_take),
        .nb_miss   (nb_miss)
    );

    // Packet phase sequencer and release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            se0_second <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) state <= ST_LEAD;
                ST_LEAD: if (bit_end) state <= ST_DATA;
                ST_DATA: begin
                    if (bit_end && bits_over) begin
                        state      <= ST_SE0;
                        se0_second <= 1'b0;
                    end
                end
                ST_SE0: begin
                    if (bit_end) begin
                        if (se0_second) state <= ST_TAIL;
                        else            se0_second <= 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (bit_end) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky underrun flag, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)       underrun_q <= 1'b0;
        else if (init)    underrun_q <= 1'b0;
        else if (nb_miss) underrun_q <= 1'b1;
    end

    // Line levels from the current phase.
    always_comb begin
        unique case (state)
            ST_DATA:          begin dp = ~lvl; dm = lvl; end
            ST_LEAD, ST_TAIL: begin dp = 1'b0; dm = 1'b1; end
            default:          begin dp = 1'b0; dm = 1'b0; end
        endcase
    end

    assign oe       = run;
    assign done     = done_q;
    assign underrun = underrun_q;

endmodule

// File: rtl/usb_ls_tx_chk.sv
// Port-level checker for the transmitter, bound to the top module.
// Assumes the line symbols change only at bit-time boundaries.
module usb_ls_tx_chk #(
    parameter int CLKS_PER_BIT = 8
) (
    input logic clk,
    input logic rst_n,
    input logic dp,
    input logic dm,
    input logic oe,
    input logic done,
    input logic in_ready
);
    localparam int SW = $clog2(2 * CLKS_PER_BIT + 1) + 2;

    logic          se0_now;
    logic [SW-1:0] se0_len;

    assign se0_now = oe && !dp && !dm;

    // Length of the current driven-SE0 stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)       se0_len <= '0;
        else if (se0_now) se0_len <= se0_len + 1'b1;
        else              se0_len <= '0;
    end

    AST_TAKE_J: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> (!dp && dm)); // R1

    AST_NO_SE1: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !(dp && dm)); // R4

    AST_SE0_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!se0_now && se0_len != '0) |-> (se0_len == SW'(2 * CLKS_PER_BIT))); // R6

    AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!oe && $past(oe))); // R6

    AST_RELEASE_FROM_J: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> $past(!dp && dm)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!dp && !dm && !in_ready)); // R10

endmodule

bind usb_ls_tx usb_ls_tx_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dp       (dp),
    .dm       (dm),
    .oe       (oe),
    .done     (done),
    .in_ready (in_ready)
);

// File: tb/usb_ls_tx_bench.sv
// Self-checking bench: decodes each packet one symbol per bit time and
// compares with a sequence computed from the coding rules.
module usb_ls_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 8;
    localparam int WD_CYCLES  = 190000;
    localparam logic [1:0] SYM_J   = 2'b01;
    localparam logic [1:0] SYM_K   = 2'b10;
    localparam logic [1:0] SYM_SE0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       hs_mode = 1'b0;
    logic [7:0] hs_pid = 8'h00;
    logic [7:0] byte_cnt = 8'h00;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready, dp, dm, oe, done, underrun;

    logic [7:0] data_mem [0:15];
    logic [7:0] pkt [0:17];
    logic [1:0] exp_sym [0:255];
    int         n_exp;
    int         feed_lim = 0;
    logic       feed_clr = 1'b0;
    int         feed_idx;
    int         n_tests = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_ls_tx #(.CLKS_PER_BIT(BIT_CLKS), .CNT_W(8)) u_usb_ls_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode),
        .hs_pid(hs_pid), .byte_cnt(byte_cnt), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .dp(dp), .dm(dm),
        .oe(oe), .done(done), .underrun(underrun)
    );

    // Byte source: offers data_mem in order up to feed_lim bytes.
    assign in_valid = (feed_idx < feed_lim);
    assign in_data  = data_mem[feed_idx[3:0]];
    always @(posedge clk) begin
        if (feed_clr)                  feed_idx <= 0;
        else if (in_valid && in_ready) feed_idx <= feed_idx + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, expv);
        end
    endtask

    // Expected line symbols for pkt[0..nbytes-1]: lead J, coded bits, EOP.
    task automatic build_exp(input int nbytes);
        logic [1:0] cur;
        int ones;
        cur = SYM_J;
        ones = 0;
        n_exp = 0;
        exp_sym[n_exp] = SYM_J; n_exp++;
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 0; i < 8; i++) begin
                if (pkt[b][i]) ones++;
                else begin cur = ~cur; ones = 0; end
                exp_sym[n_exp] = cur; n_exp++;
                if (ones == 6) begin
                    cur = ~cur; ones = 0;
                    exp_sym[n_exp] = cur; n_exp++;
                end
            end
        end
        exp_sym[n_exp] = SYM_SE0; n_exp++;
        exp_sym[n_exp] = SYM_SE0; n_exp++;
        exp_sym[n_exp] = SYM_J;   n_exp++;
    endtask

    task automatic run_pkt(input bit hs, input logic [7:0] pid, input int cnt,
                           input int nfeed, input bit poke, input string tag);
        int owed, nsent, bad_k;
        bit exp_und, rdy_seen;
        logic [1:0] bad_act;
        owed    = hs ? 1 : ((cnt == 0) ? 0 : cnt - 1);
        exp_und = !hs && (nfeed < owed);
        nsent   = exp_und ? nfeed : owed;
        pkt[0]  = 8'h80;
        for (int b = 0; b < nsent; b++) pkt[b + 1] = hs ? pid : data_mem[b];
        build_exp(nsent + 1);

        feed_lim = nfeed;
        feed_clr = 1'b1;
        @(negedge clk);
        feed_clr = 1'b0;
        hs_mode  = hs;
        hs_pid   = pid;
        byte_cnt = cnt[7:0];
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(oe === 1'b1, "R1", {tag, " oe one cycle after start"}, 32'(oe), 1);

        bad_k = -1;
        bad_act = 2'b00;
        rdy_seen = 1'b0;
        for (int k = 0; k < n_exp; k++) begin
            if (bad_k < 0 && ({dp, dm} !== exp_sym[k] || oe !== 1'b1)) begin
                bad_k = k;
                bad_act = {dp, dm};
            end
            for (int c = 0; c < BIT_CLKS; c++) begin
                start = (poke && k == 5 && c == 0);
                if (in_ready) rdy_seen = 1'b1;
                @(negedge clk);
            end
            start = 1'b0;
        end
        chk(bad_k < 0, "R2 R3 R4 R5", {tag, " symbol sequence"},
            32'(bad_act), (bad_k < 0) ? 32'(0) : 32'(exp_sym[bad_k]));
        chk(oe === 1'b0 && done === 1'b1 && dp === 1'b0 && dm === 1'b0, "R6",
            {tag, " release {oe,done,dp,dm}"}, 32'({oe, done, dp, dm}), 32'b0100);
        chk(underrun === exp_und, "R8", {tag, " underrun flag"},
            32'(underrun), 32'(exp_und));
        if (hs)
            chk(!rdy_seen, "R9", {tag, " in_ready during handshake"},
                32'(rdy_seen), 0);
        else
            chk(feed_idx == nsent, "R7", {tag, " bytes accepted"},
                32'(feed_idx), 32'(nsent));
        @(negedge clk);
        chk(done === 1'b0 && oe === 1'b0, "R6", {tag, " done single cycle"},
            32'({done, oe}), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        feed_clr = 1'b1;
        repeat (4) @(negedge clk);
        chk({oe, dp, dm, in_ready, done, underrun} === 6'b0, "R11",
            "outputs in reset", 32'({oe, dp, dm, in_ready, done, underrun}), 0);
        rst_n = 1'b1;
        feed_clr = 1'b0;
        @(negedge clk);
        chk({oe, dp, dm, in_ready, done, underrun} === 6'b0, "R11",
            "outputs after reset", 32'({oe, dp, dm, in_ready, done, underrun}), 0);

        // R3: lengths that carry no payload.
        run_pkt(1'b0, 8'h00, 0, 0, 1'b0, "R3 cnt0");
        run_pkt(1'b0, 8'h00, 1, 0, 1'b0, "R3 cnt1");

        // R4 R5: every single-byte payload.
        for (int v = 0; v < 256; v++) begin
            data_mem[0] = 8'(v);
            run_pkt(1'b0, 8'h00, 2, 1, 1'b0, "R4 sweep");
        end

        // R5: stuffing across bytes and before the end-of-packet.
        for (int i = 0; i < 3; i++) data_mem[i] = 8'hFF;
        run_pkt(1'b0, 8'h00, 4, 3, 1'b0, "R5 ones");
        data_mem[0] = 8'hC0; data_mem[1] = 8'h0F;
        run_pkt(1'b0, 8'h00, 3, 2, 1'b0, "R5 cross");
        data_mem[0] = 8'h5A; data_mem[1] = 8'hFC;
        run_pkt(1'b0, 8'h00, 3, 2, 1'b0, "R5 tail");

        // R4 R7 R1: back-to-back zero bytes with a start pulse mid-packet.
        for (int i = 0; i < 4; i++) data_mem[i] = 8'h00;
        run_pkt(1'b0, 8'h00, 5, 4, 1'b1, "R1 busy start");

        // R9: handshake replies with bytes offered on the unused port.
        for (int i = 0; i < 4; i++) data_mem[i] = 8'hA5;
        run_pkt(1'b1, 8'hD2, 7, 4, 1'b0, "R9 ack");
        run_pkt(1'b1, 8'h5A, 0, 4, 1'b0, "R9 nak");

        // R8: too few bytes supplied, then a clean packet clears the flag.
        data_mem[0] = 8'h3C;
        run_pkt(1'b0, 8'h00, 4, 1, 1'b0, "R8 short");
        run_pkt(1'b0, 8'h00, 3, 0, 1'b0, "R8 none");
        data_mem[0] = 8'h81;
        run_pkt(1'b0, 8'h00, 2, 1, 1'b0, "R8 cleared");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule